// File: doc/BRIEF.md
# Affine Coordinate Transform Processor

A very small 8-bit processor built for one job: mapping a 2-D pixel coordinate through a fixed affine transform. Its control path is a program counter, a constant program store and an opcode decoder. Its datapath is a 32-entry register file, an ALU that can add and mask, and a signed multiplier that scales by a fraction. The stored program polls a handshake switch, reads two coordinates from eight data switches and computes two results. It computes x2 = a11·x1 + a12·y1 + b1 and y2 = a21·x1 + a22·y1 + b2, and shows them one after the other on eight LEDs.

There are no dedicated I/O instructions. Reading register 1 returns the live data switches. Reading register 2 returns the handshake switch as a 0/1 byte. The LEDs are wired straight to register 3. The six coefficients are immediate fields in the program. Every instruction completes in one clock.

Top module: `affine_cpu`

## Requirements
- R1: While `sw[9]` is 0, each clock edge sets the program counter to 0 and every register, including the LED register, to 0. After `sw[9]` returns to 1, execution starts at the wait loop for x1.
- R2: An instruction is 24 bits: opcode in [23:18], destination register in [17:13], source register in [12:8] and an 8-bit immediate in [7:0]. Each instruction takes one clock. A non-branching instruction advances the program counter by one, and the counter never leaves the stored program.
- R3: Register 0 reads 0. Register 1 reads `sw[7:0]`. Register 2 reads 1 when `sw[8]` is 1 and 0 otherwise. Writes to registers 0 to 2 are discarded. `led` always shows register 3, and `led` changes only when register 3 is written or reset applies.
- R4: Multiplying by a coefficient forms the 16-bit signed product of the register value and the 8-bit immediate. The immediate is a fraction with its sign bit weighted -1. Bits [14:7] of the product are kept, which is the product divided by 128 and rounded toward minus infinity.
- R5: Every ALU instruction updates a zero flag. A conditional branch tests the flag left by the previous instruction. A taken branch loads the program counter from the low 5 bits of the immediate.
- R6: x1 is the value on `sw[7:0]` at the first rise of `sw[8]`. y1 is taken only after `sw[8]` has fallen and then risen again.
- R7: After the second fall of `sw[8]`, `led` shows x2 = (⌊a11·x1/128⌋ + ⌊a12·y1/128⌋ + b1) mod 256. It holds that value until `sw[8]` rises.
- R8: When `sw[8]` then rises, `led` shows y2, computed the same way with a21, a22 and b2. When `sw[8]` falls again, the program returns to waiting for x1, and `led` keeps y2 until the next x2.
- R9: Changes on `sw[7:0]` at any time other than the two latching rises have no effect on the results.
- R10: The default coefficients are a11 = 0x60 (0.75), a12 = 0x40 (0.5), a21 = 0xC0 (-0.5), a22 = 0x60 (0.75), b1 = 20 and b2 = -20.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| sw | input | 10 | [7:0] coordinate data, [8] handshake, [9] active-low reset |
| led | output | 8 | Contents of register 3, the displayed coordinate |

## Verification
The assertions check on every cycle the properties that hold from one instruction to the next. These are the reset state, a program counter that either steps by one or lands on the branch target, a zero flag that matches the previous ALU result, and an LED register that moves only when register 3 is written. Only the bench's scenarios can show what the program does as a whole. That covers the handshake ordering, which switch value becomes x1 or y1, and the multiply truncation and wrap-around in the displayed x2 and y2. It also covers indifference to data changes between latches and a clean restart after a reset in mid-sequence.

// File: rtl/affine_cpu_pkg.sv
package affine_cpu_pkg;
  localparam int DW       = 8;
  localparam int NREG     = 32;
  localparam int RIDX_W   = $clog2(NREG);
  localparam int OP_W     = 6;
  localparam int IW       = OP_W + 2 * RIDX_W + DW;
  localparam int PC_W     = 5;
  localparam int ROM_SIZE = 1 << PC_W;
  localparam int PROG_LEN = 23;

  localparam logic [RIDX_W-1:0] ZERO_IDX = RIDX_W'(0);
  localparam logic [RIDX_W-1:0] IN_IDX   = RIDX_W'(1);
  localparam logic [RIDX_W-1:0] HS_IDX   = RIDX_W'(2);
  localparam logic [RIDX_W-1:0] LED_IDX  = RIDX_W'(3);
  localparam int FIRST_WR = 3;

  typedef enum logic [OP_W-1:0] {
    OP_NOP  = 6'h00,
    OP_ADD  = 6'h01,
    OP_ADDI = 6'h02,
    OP_ANDI = 6'h03,
    OP_MULI = 6'h04,
    OP_BZ   = 6'h10,
    OP_BNZ  = 6'h11,
    OP_JMP  = 6'h12
  } opcode_e;

  typedef enum logic [1:0] {FN_ADD, FN_AND, FN_MUL} alu_fn_e;
  typedef enum logic [1:0] {BR_NONE, BR_Z, BR_NZ, BR_ALWAYS} br_kind_e;

  typedef struct packed {
    alu_fn_e  fn;
    logic     use_imm;
    logic     a_from_rd;
    logic     reg_we;
    logic     flag_we;
    br_kind_e br;
  } ctrl_t;

  // Signed integer times signed fraction (sign bit weight -1), floor of product/128.
  function automatic logic [DW-1:0] frac_mul(input logic [DW-1:0] a, input logic [DW-1:0] c);
    logic signed [2*DW-1:0] p;
    p = $signed(a) * $signed(c);
    return p[2*DW-2:DW-1];
  endfunction

  function automatic logic [IW-1:0] enc(input opcode_e op, input logic [RIDX_W-1:0] rd,
                                        input logic [RIDX_W-1:0] rs, input logic [DW-1:0] imm);
    return {op, rd, rs, imm};
  endfunction
endpackage

// File: rtl/acp_prog_rom.sv
module acp_prog_rom
  import affine_cpu_pkg::*;
#(
  parameter logic [DW-1:0] A11 = 8'h60,
  parameter logic [DW-1:0] A12 = 8'h40,
  parameter logic [DW-1:0] A21 = 8'hC0,
  parameter logic [DW-1:0] A22 = 8'h60,
  parameter logic [DW-1:0] B1  = 8'd20,
  parameter logic [DW-1:0] B2  = 8'hEC
) (
  input  logic [PC_W-1:0] pc,
  output logic [IW-1:0]   instr
);
  localparam logic [DW-1:0] L_WAIT_X1 = DW'(0);
  localparam logic [DW-1:0] L_REL_X1  = DW'(3);
  localparam logic [DW-1:0] L_WAIT_Y1 = DW'(5);
  localparam logic [DW-1:0] L_REL_Y1  = DW'(8);
  localparam logic [DW-1:0] L_WAIT_Y2 = DW'(14);
  localparam logic [DW-1:0] L_REL_Y2  = DW'(20);
  localparam logic [DW-1:0] HS_MASK   = DW'(1);

  localparam logic [RIDX_W-1:0] R_X  = RIDX_W'(4);
  localparam logic [RIDX_W-1:0] R_Y  = RIDX_W'(5);
  localparam logic [RIDX_W-1:0] R_T0 = RIDX_W'(6);
  localparam logic [RIDX_W-1:0] R_T1 = RIDX_W'(7);

  always_comb begin
    case (pc)
      5'd0:    instr = enc(OP_ANDI, ZERO_IDX, HS_IDX, HS_MASK);
      5'd1:    instr = enc(OP_BZ,   ZERO_IDX, ZERO_IDX, L_WAIT_X1);
      5'd2:    instr = enc(OP_ADDI, R_X, IN_IDX, 8'd0);
      5'd3:    instr = enc(OP_ANDI, ZERO_IDX, HS_IDX, HS_MASK);
      5'd4:    instr = enc(OP_BNZ,  ZERO_IDX, ZERO_IDX, L_REL_X1);
      5'd5:    instr = enc(OP_ANDI, ZERO_IDX, HS_IDX, HS_MASK);
      5'd6:    instr = enc(OP_BZ,   ZERO_IDX, ZERO_IDX, L_WAIT_Y1);
      5'd7:    instr = enc(OP_ADDI, R_Y, IN_IDX, 8'd0);
      5'd8:    instr = enc(OP_ANDI, ZERO_IDX, HS_IDX, HS_MASK);
      5'd9:    instr = enc(OP_BNZ,  ZERO_IDX, ZERO_IDX, L_REL_Y1);
      5'd10:   instr = enc(OP_MULI, R_T0, R_X, A11);
      5'd11:   instr = enc(OP_MULI, R_T1, R_Y, A12);
      5'd12:   instr = enc(OP_ADD,  R_T0, R_T1, 8'd0);
      5'd13:   instr = enc(OP_ADDI, LED_IDX, R_T0, B1);
      5'd14:   instr = enc(OP_ANDI, ZERO_IDX, HS_IDX, HS_MASK);
      5'd15:   instr = enc(OP_BZ,   ZERO_IDX, ZERO_IDX, L_WAIT_Y2);
      5'd16:   instr = enc(OP_MULI, R_T0, R_X, A21);
      5'd17:   instr = enc(OP_MULI, R_T1, R_Y, A22);
      5'd18:   instr = enc(OP_ADD,  R_T0, R_T1, 8'd0);
      5'd19:   instr = enc(OP_ADDI, LED_IDX, R_T0, B2);
      5'd20:   instr = enc(OP_ANDI, ZERO_IDX, HS_IDX, HS_MASK);
      5'd21:   instr = enc(OP_BNZ,  ZERO_IDX, ZERO_IDX, L_REL_Y2);
      5'd22:   instr = enc(OP_JMP,  ZERO_IDX, ZERO_IDX, L_WAIT_X1);
      default: instr = enc(OP_JMP,  ZERO_IDX, ZERO_IDX, L_WAIT_X1);
    endcase
  end
endmodule

// File: rtl/acp_decoder.sv
module acp_decoder
  import affine_cpu_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  output ctrl_t           ctrl
);
  always_comb begin
    ctrl = '{fn: FN_ADD, use_imm: 1'b0, a_from_rd: 1'b0, reg_we: 1'b0,
             flag_we: 1'b0, br: BR_NONE};
    case (opcode_e'(opcode))
      OP_ADD:  begin ctrl.a_from_rd = 1'b1; ctrl.reg_we = 1'b1; ctrl.flag_we = 1'b1; end
      OP_ADDI: begin ctrl.use_imm = 1'b1; ctrl.reg_we = 1'b1; ctrl.flag_we = 1'b1; end
      OP_ANDI: begin ctrl.fn = FN_AND; ctrl.use_imm = 1'b1; ctrl.reg_we = 1'b1; ctrl.flag_we = 1'b1; end
      OP_MULI: begin ctrl.fn = FN_MUL; ctrl.use_imm = 1'b1; ctrl.reg_we = 1'b1; ctrl.flag_we = 1'b1; end
      OP_BZ:   ctrl.br = BR_Z;
      OP_BNZ:  ctrl.br = BR_NZ;
      OP_JMP:  ctrl.br = BR_ALWAYS;
      default: ;
    endcase
  end
endmodule

// File: rtl/acp_regfile.sv
module acp_regfile
  import affine_cpu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DW-1:0]     in_data,
  input  logic              hs,
  input  logic [RIDX_W-1:0] a_idx,
  input  logic [RIDX_W-1:0] b_idx,
  output logic [DW-1:0]     a_data,
  output logic [DW-1:0]     b_data,
  input  logic              wr_en,
  input  logic [RIDX_W-1:0] wr_idx,
  input  logic [DW-1:0]     wr_data,
  output logic [DW-1:0]     led_q
);
  logic [DW-1:0] store [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g < FIRST_WR) begin : g_fixed
      assign store[g] = '0;
    end else begin : g_rw
      always_ff @(posedge clk) begin
        if (!rst_n)                                   store[g] <= '0;
        else if (wr_en && wr_idx == RIDX_W'(g))       store[g] <= wr_data;
      end
    end
  end

  logic [RIDX_W-1:0] rd_idx [2];
  logic [DW-1:0]     rd_val [2];
  assign rd_idx[0] = a_idx;
  assign rd_idx[1] = b_idx;

  for (genvar p = 0; p < 2; p++) begin : g_port
    always_comb begin
      if (rd_idx[p] == IN_IDX)      rd_val[p] = in_data;
      else if (rd_idx[p] == HS_IDX) rd_val[p] = {{(DW-1){1'b0}}, hs};
      else                          rd_val[p] = store[rd_idx[p]];
    end
  end

  assign a_data = rd_val[0];
  assign b_data = rd_val[1];
  assign led_q  = store[LED_IDX];
endmodule

// File: rtl/acp_alu.sv
module acp_alu
  import affine_cpu_pkg::*;
(
  input  alu_fn_e       fn,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y
);
  always_comb begin
    case (fn)
      FN_AND:  y = a & b;
      FN_MUL:  y = frac_mul(a, b);
      default: y = a + b;
    endcase
  end
endmodule

// File: rtl/affine_cpu.sv
module affine_cpu
  import affine_cpu_pkg::*;
#(
  parameter logic [DW-1:0] A11 = 8'h60,
  parameter logic [DW-1:0] A12 = 8'h40,
  parameter logic [DW-1:0] A21 = 8'hC0,
  parameter logic [DW-1:0] A22 = 8'h60,
  parameter logic [DW-1:0] B1  = 8'd20,
  parameter logic [DW-1:0] B2  = 8'hEC
) (
  input  logic       clk,
  input  logic [9:0] sw,
  output logic [7:0] led
);
  logic rst_n;
  assign rst_n = sw[9];

  logic [PC_W-1:0]   pc, next_pc, br_target;
  logic [IW-1:0]     instr;
  logic [OP_W-1:0]   f_op;
  logic [RIDX_W-1:0] f_rd, f_rs;
  logic [DW-1:0]     f_imm;
  ctrl_t             ctrl;
  logic              z_flag, br_taken;
  logic [DW-1:0]     a_data, b_data, alu_b, alu_y;
  logic              wr_en, flag_we;
  logic [RIDX_W-1:0] wr_idx;

  acp_prog_rom #(.A11(A11), .A12(A12), .A21(A21), .A22(A22), .B1(B1), .B2(B2))
    u_rom (.pc(pc), .instr(instr));

  assign {f_op, f_rd, f_rs, f_imm} = instr;

  acp_decoder u_dec (.opcode(f_op), .ctrl(ctrl));

  assign wr_en   = ctrl.reg_we;
  assign wr_idx  = f_rd;
  assign flag_we = ctrl.flag_we;

  acp_regfile u_rf (
    .clk(clk), .rst_n(rst_n), .in_data(sw[7:0]), .hs(sw[8]),
    .a_idx(ctrl.a_from_rd ? f_rd : f_rs), .b_idx(f_rs),
    .a_data(a_data), .b_data(b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(alu_y), .led_q(led)
  );

  assign alu_b = ctrl.use_imm ? f_imm : b_data;

  acp_alu u_alu (.fn(ctrl.fn), .a(a_data), .b(alu_b), .y(alu_y));

  always_comb begin
    case (ctrl.br)
      BR_Z:      br_taken = z_flag;
      BR_NZ:     br_taken = !z_flag;
      BR_ALWAYS: br_taken = 1'b1;
      default:   br_taken = 1'b0;
    endcase
  end

  assign br_target = f_imm[PC_W-1:0];
  assign next_pc   = br_taken ? br_target : pc + PC_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc     <= '0;
      z_flag <= 1'b0;
    end else begin
      pc <= next_pc;
      if (flag_we) z_flag <= (alu_y == '0);
    end
  end
endmodule

// File: rtl/acp_checker.sv
module acp_checker
  import affine_cpu_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [PC_W-1:0]   pc,
  input logic [PC_W-1:0]   br_target,
  input logic              br_taken,
  input logic [DW-1:0]     led,
  input logic              wr_en,
  input logic [RIDX_W-1:0] wr_idx,
  input logic              flag_we,
  input logic [DW-1:0]     alu_y,
  input logic              z_flag
);
  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (pc == '0 && led == '0));

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !br_taken |=> pc == PC_W'($past(pc) + PC_W'(1)));

  assert_pc_in_program_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pc < PC_W'(PROG_LEN));

  assert_led_write_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_idx == LED_IDX) |=> $stable(led));

  assert_branch_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |=> pc == $past(br_target));

  assert_zero_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |=> z_flag == ($past(alu_y) == '0));
endmodule

bind affine_cpu acp_checker u_chk (
  .clk(clk), .rst_n(rst_n), .pc(pc), .br_target(br_target), .br_taken(br_taken),
  .led(led), .wr_en(wr_en), .wr_idx(wr_idx), .flag_we(flag_we), .alu_y(alu_y),
  .z_flag(z_flag)
);

// File: tb/affine_cpu_test.sv
`timescale 1ns/1ps
module affine_cpu_test;
  logic       clk = 1'b0;
  logic [9:0] sw;
  logic [7:0] led;
  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  affine_cpu uut (.clk(clk), .sw(sw), .led(led));

  always #5 clk = ~clk;

  // R10 default coefficients
  localparam int C11 = 96, C12 = 64, C21 = -64, C22 = 96, K1 = 20, K2 = -20;

  function automatic int floor_div128(input int p);
    int q;
    q = p / 128;
    if (p < 0 && (p % 128) != 0) q = q - 1;
    return q;
  endfunction

  function automatic logic [7:0] expect_out(input int ca, input int cb, input int k,
                                            input logic [7:0] u, input logic [7:0] v);
    int s;
    s = floor_div128(ca * int'($signed(u))) + floor_div128(cb * int'($signed(v))) + k;
    return s[7:0];
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input logic [7:0] got,
                       input logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %02h expected %02h", req, what, got, exp);
    end
  endtask

  task automatic set_in(input logic hs, input logic [7:0] d);
    sw = {1'b1, hs, d};
  endtask

  // One full handshake round; junk is placed on the data switches between latches.
  task automatic run_pair(input logic [7:0] x1, input logic [7:0] y1, input logic [7:0] junk);
    logic [7:0] ex2, ey2;
    ex2 = expect_out(C11, C12, K1, x1, y1);
    ey2 = expect_out(C21, C22, K2, x1, y1);
    set_in(1'b0, junk);       step(8);   // R9 data wiggle before the x1 latch
    set_in(1'b1, x1);         step(10);  // R6 x1 latched on the rise
    set_in(1'b1, ~x1);        step(6);   // R9 change while held
    set_in(1'b0, junk);       step(10);
    set_in(1'b1, y1);         step(10);  // R6 y1 on the second rise
    set_in(1'b0, ~y1);        step(14);
    check("R7", "x2 shown", led, ex2);
    set_in(1'b0, junk);       step(10);
    check("R7", "x2 held", led, ex2);
    set_in(1'b1, junk);       step(14);
    check("R8", "y2 shown", led, ey2);
    set_in(1'b0, ~junk);      step(14);
    check("R8", "y2 kept after loop", led, ey2);
  endtask

  task automatic test_reset;
    sw = 10'h0;
    step(4);
    check("R1", "led in reset", led, 8'h00);
    set_in(1'b0, 8'h5A);
    step(6);
    check("R1", "led after release", led, 8'h00);
  endtask

  task automatic test_mid_reset;
    set_in(1'b1, 8'd6);  step(10);
    set_in(1'b0, 8'd0);  step(10);
    set_in(1'b1, 8'd20); step(10);
    set_in(1'b0, 8'd0);  step(14);
    check("R7", "x2 before reset", led, expect_out(C11, C12, K1, 8'd6, 8'd20));
    sw = {1'b0, 1'b1, 8'h77};
    step(3);
    check("R1", "led cleared by reset", led, 8'h00);
    set_in(1'b0, 8'h00);
    step(6);
    check("R1", "led stays 0 while waiting x1", led, 8'h00);
    run_pair(8'd10, 8'hF6, 8'h33);   // R1 restart at x1
  endtask

  initial begin
    sw = 10'h0;
    test_reset();
    run_pair(8'd6, 8'd20, 8'h55);     // R4 examples: 0.75*6 -> 4
    run_pair(8'd0, 8'd0, 8'hFF);      // R7 offsets only
    run_pair(8'h80, 8'h7F, 8'h01);    // R4 extremes
    run_pair(8'h7F, 8'h80, 8'hA5);    // R7 wrap
    run_pair(8'hFF, 8'hFF, 8'h00);    // R4 floor of -0.75
    run_pair(8'hEC, 8'd20, 8'h3C);    // R4 -0.5*-20 and negatives
    test_mid_reset();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule